// File: doc/BRIEF.md
# Retention Unit Tuner

This block chooses which of four storage units an application's cache traffic should use. Each unit holds data for a different length of time: index 0 is the 100 µs unit, 1 the 1 ms unit, 2 the 10 ms unit and 3 the 100 ms unit. A shorter retention time costs less write energy, but blocks may expire before they are used again, and those blocks come back as extra misses. The tuner bases its choice on miss counts gathered over fixed tuning intervals. Those intervals are nominally 100 million instructions long and are counted outside the block.

Tuning begins on the 100 ms unit. The misses from that first interval become the reference value for the whole run. The shorter units are then tried one interval each, in order of falling retention time. The search keeps going while a candidate's misses stay under 105% of the reference. It stops at the first candidate that misses that bound, and the last good unit is restored. An optional mode also accepts any candidate whose miss rate is under 0.05% of accesses. Once a unit is settled, every later interval is compared with the reference, and a clear rise in misses starts a fresh search.

Every change of selected unit raises a migration request. The block then waits for an external agent to finish moving the cache state, and interval results that arrive during that wait are discarded.

Top module: `ret_unit_tuner`

## Requirements
- R1: After reset, unit_sel is 3 (100 ms unit) and mig_req is 0, and the first completed interval is treated as the baseline measurement.
- R2: An interval completing during the baseline phase stores miss_cnt as the reference and selects unit 2 with mig_req raised.
- R3: During the search, a candidate with miss_cnt*20 < reference*21 is accepted, and the next shorter unit (index minus one) is selected with mig_req raised.
- R4: A candidate that is not accepted (miss_cnt*20 >= reference*21, and the low-rate rule does not apply) causes the last accepted unit to be selected again with mig_req raised, after which monitoring begins.
- R5: When unit 0 is accepted, the search ends on unit 0 without a migration request and monitoring begins.
- R6: During monitoring, an interval with miss_cnt*20 > reference*21 selects unit 3 with mig_req raised and restarts from the baseline phase. An interval with miss_cnt*20 <= reference*21 changes nothing.
- R7: With low_base_mode at 1, an interval with miss_cnt*2000 < acc_cnt counts as a pass: a candidate is accepted and the search continues, and during monitoring it does not trigger a re-tune. With low_base_mode at 0 this rule is not applied.
- R8: unit_sel changes only on the clock edge where mig_req rises (except the no-migration cases of R5 and R10). mig_req then stays high, and unit_sel stays stable, until mig_done is seen high at a clock edge. mig_req is low in the following cycle.
- R9: An ivl_done pulse that arrives while mig_req is high is ignored: neither the unit, the reference nor the search position changes.
- R10: A re-tune triggered while monitoring unit 3 needs no migration: mig_req stays 0, and the next interval is taken as the new reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ivl_done | input | 1 | One-cycle pulse marking the end of a tuning interval |
| miss_cnt | input | CNT_W | Misses counted over the interval just ended |
| acc_cnt | input | CNT_W | Accesses counted over the interval just ended |
| low_base_mode | input | 1 | 1 enables acceptance by low miss rate |
| mig_done | input | 1 | Migration agent finished moving state to the selected unit |
| unit_sel | output | SEL_W | Selected retention unit, 0 = shortest, 3 = longest |
| mig_req | output | 1 | Request to migrate state to the unit on unit_sel |

## Verification
The bench places miss counts exactly on the 105% bound. A design that rounds the tolerance, or that mixes up the strict test used for acceptance with the strict test used for drift, would then either keep a unit it should leave or re-tune when it should stay put. It runs one search all the way down to unit 0, where a design that migrates "one past" the last unit would wrap to unit 3. It also runs one search that is rejected at the first candidate, where the return must go to unit 3 and not to the rejected unit. Interval pulses are fired while a migration is still pending: a design that does not gate them would move on and skip a measurement. In the low-rate mode the bench sets the miss rate exactly at 0.05%, and it also triggers a drift while unit 3 is selected, where a design that handles this badly would raise a migration to the unit it already has.

// File: rtl/ret_unit_tuner_pkg.sv
package ret_unit_tuner_pkg;

  // Tolerance: misses may grow to TOL_NUM/TOL_DEN of the reference (1.05x).
  parameter int unsigned TOL_NUM  = 21;
  parameter int unsigned TOL_DEN  = 20;
  // Low-rate rule: misses below 1/RATE_DIV of the accesses (0.05%).
  parameter int unsigned RATE_DIV = 2000;

  // Counts are zero-extended to this width before scaling (CNT_W <= 48).
  typedef logic [63:0] wide_t;

  typedef enum logic [1:0] {
    PH_BASE    = 2'd0,
    PH_TRY     = 2'd1,
    PH_MIGRATE = 2'd2,
    PH_MONITOR = 2'd3
  } phase_e;

  // Candidate stays strictly inside the tolerance band.
  function automatic logic inside_band(input wide_t miss, input wide_t ref_miss);
    return (miss * 64'(TOL_DEN)) < (ref_miss * 64'(TOL_NUM));
  endfunction

  // Monitored unit strictly above the tolerance band.
  function automatic logic above_band(input wide_t miss, input wide_t ref_miss);
    return (miss * 64'(TOL_DEN)) > (ref_miss * 64'(TOL_NUM));
  endfunction

  // Miss rate strictly below the low-rate limit.
  function automatic logic rate_is_low(input wide_t miss, input wide_t acc);
    return (miss * 64'(RATE_DIV)) < acc;
  endfunction

endpackage

// File: rtl/rt_base_hold.sv
module rt_base_hold #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [CNT_W-1:0] miss_in,
  output logic [CNT_W-1:0] ref_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
    end else if (capture) begin
      ref_q <= miss_in;
    end
  end

endmodule

// File: rtl/rt_miss_judge.sv
module rt_miss_judge
  import ret_unit_tuner_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic [CNT_W-1:0] miss_cnt,
  input  logic [CNT_W-1:0] acc_cnt,
  input  logic [CNT_W-1:0] ref_miss,
  input  logic             low_base_mode,
  output logic             cand_ok,
  output logic             drift
);

  logic in_band;
  logic over_band;
  logic low_rate;

  always_comb begin
    in_band   = inside_band(64'(miss_cnt), 64'(ref_miss));
    over_band = above_band(64'(miss_cnt), 64'(ref_miss));
    low_rate  = low_base_mode && rate_is_low(64'(miss_cnt), 64'(acc_cnt));
    cand_ok   = in_band || low_rate;
    drift     = over_band && !low_rate;
  end

endmodule

// File: rtl/rt_search_fsm.sv
module rt_search_fsm
  import ret_unit_tuner_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int SEL_W     = $clog2(NUM_UNITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ivl_done,
  input  logic             cand_ok,
  input  logic             drift,
  input  logic             mig_done,
  output logic [SEL_W-1:0] unit_sel,
  output logic             mig_req,
  output logic             ev_base_capture,
  output logic             ev_accept,
  output logic             ev_reject,
  output logic             ev_drift
);

  localparam logic [SEL_W-1:0] LONGEST = SEL_W'(NUM_UNITS - 1);
  localparam logic [SEL_W-1:0] SHORTEST = '0;

  phase_e           phase_q, phase_n;
  phase_e           after_q, after_n;
  logic [SEL_W-1:0] sel_q, sel_n;
  logic [SEL_W-1:0] keep_q, keep_n;

  // Named events for the checker.
  always_comb begin
    ev_base_capture = ivl_done && (phase_q == PH_BASE);
    ev_accept       = ivl_done && (phase_q == PH_TRY) && cand_ok;
    ev_reject       = ivl_done && (phase_q == PH_TRY) && !cand_ok;
    ev_drift        = ivl_done && (phase_q == PH_MONITOR) && drift;
  end

  always_comb begin
    phase_n = phase_q;
    after_n = after_q;
    sel_n   = sel_q;
    keep_n  = keep_q;
    unique case (phase_q)
      PH_BASE: begin
        if (ev_base_capture) begin
          keep_n  = LONGEST;
          sel_n   = LONGEST - SEL_W'(1);
          after_n = PH_TRY;
          phase_n = PH_MIGRATE;
        end
      end
      PH_TRY: begin
        if (ev_accept) begin
          keep_n = sel_q;
          if (sel_q == SHORTEST) begin
            phase_n = PH_MONITOR;
          end else begin
            sel_n   = sel_q - SEL_W'(1);
            after_n = PH_TRY;
            phase_n = PH_MIGRATE;
          end
        end else if (ev_reject) begin
          sel_n   = keep_q;
          after_n = PH_MONITOR;
          phase_n = PH_MIGRATE;
        end
      end
      PH_MONITOR: begin
        if (ev_drift) begin
          if (sel_q == LONGEST) begin
            phase_n = PH_BASE;
          end else begin
            sel_n   = LONGEST;
            after_n = PH_BASE;
            phase_n = PH_MIGRATE;
          end
        end
      end
      PH_MIGRATE: begin
        if (mig_done) begin
          phase_n = after_q;
        end
      end
      default: phase_n = PH_BASE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_BASE;
      after_q <= PH_TRY;
      sel_q   <= LONGEST;
      keep_q  <= LONGEST;
    end else begin
      phase_q <= phase_n;
      after_q <= after_n;
      sel_q   <= sel_n;
      keep_q  <= keep_n;
    end
  end

  assign unit_sel = sel_q;
  assign mig_req  = (phase_q == PH_MIGRATE);

endmodule

// File: rtl/ret_unit_tuner.sv
module ret_unit_tuner #(
  parameter int NUM_UNITS = 4,
  parameter int CNT_W     = 32,
  parameter int SEL_W     = $clog2(NUM_UNITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ivl_done,
  input  logic [CNT_W-1:0] miss_cnt,
  input  logic [CNT_W-1:0] acc_cnt,
  input  logic             low_base_mode,
  input  logic             mig_done,
  output logic [SEL_W-1:0] unit_sel,
  output logic             mig_req
);

  logic [CNT_W-1:0] ref_miss;
  logic             cand_ok;
  logic             drift;
  logic             ev_base_capture;
  logic             ev_accept;
  logic             ev_reject;
  logic             ev_drift;

  rt_base_hold #(.CNT_W(CNT_W)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (ev_base_capture),
    .miss_in (miss_cnt),
    .ref_q   (ref_miss)
  );

  rt_miss_judge #(.CNT_W(CNT_W)) u_judge (
    .miss_cnt      (miss_cnt),
    .acc_cnt       (acc_cnt),
    .ref_miss      (ref_miss),
    .low_base_mode (low_base_mode),
    .cand_ok       (cand_ok),
    .drift         (drift)
  );

  rt_search_fsm #(.NUM_UNITS(NUM_UNITS), .SEL_W(SEL_W)) u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .ivl_done        (ivl_done),
    .cand_ok         (cand_ok),
    .drift           (drift),
    .mig_done        (mig_done),
    .unit_sel        (unit_sel),
    .mig_req         (mig_req),
    .ev_base_capture (ev_base_capture),
    .ev_accept       (ev_accept),
    .ev_reject       (ev_reject),
    .ev_drift        (ev_drift)
  );

endmodule

// File: rtl/ret_unit_tuner_chk.sv
module ret_unit_tuner_chk #(
  parameter int NUM_UNITS = 4,
  parameter int SEL_W     = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ivl_done,
  input logic             mig_done,
  input logic [SEL_W-1:0] unit_sel,
  input logic             mig_req,
  input logic             ev_base_capture,
  input logic             ev_accept,
  input logic             ev_reject,
  input logic             ev_drift
);

  localparam logic [SEL_W-1:0] LONGEST = SEL_W'(NUM_UNITS - 1);

  // R8
  mig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mig_req && !mig_done) |=> mig_req);

  // R8
  mig_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mig_req && mig_done) |=> !mig_req);

  // R8
  sel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mig_req |=> $stable(unit_sel));

  // R8
  sel_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(unit_sel) |-> $rose(mig_req));

  // R9
  ivl_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mig_req && ivl_done && !mig_done) |=> (mig_req && $stable(unit_sel)));

  // R2
  base_on_longest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_base_capture |-> (unit_sel == LONGEST));

  // R2
  base_to_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_base_capture |=> (mig_req && unit_sel == LONGEST - SEL_W'(1)));

  // R3
  accept_shorter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && unit_sel != '0) |=> (mig_req && unit_sel == $past(unit_sel) - SEL_W'(1)));

  // R4
  reject_longer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> (mig_req && unit_sel > $past(unit_sel)));

  // R5
  bottom_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && unit_sel == '0) |=> (!mig_req && unit_sel == '0));

  // R6
  drift_longest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drift |=> (unit_sel == LONGEST));

  // R10
  drift_no_mig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_drift && unit_sel == LONGEST) |=> !mig_req);

  // R1
  events_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_base_capture, ev_accept, ev_reject, ev_drift}));

endmodule

bind ret_unit_tuner ret_unit_tuner_chk #(.NUM_UNITS(NUM_UNITS), .SEL_W(SEL_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .ivl_done        (ivl_done),
  .mig_done        (mig_done),
  .unit_sel        (unit_sel),
  .mig_req         (mig_req),
  .ev_base_capture (ev_base_capture),
  .ev_accept       (ev_accept),
  .ev_reject       (ev_reject),
  .ev_drift        (ev_drift)
);

// File: tb/ret_unit_tuner_bench.sv
module ret_unit_tuner_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 32;
  localparam int WATCHDOG   = 100000;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             ivl_done;
  logic [CNT_W-1:0] miss_cnt;
  logic [CNT_W-1:0] acc_cnt;
  logic             low_base_mode;
  logic             mig_done;
  logic [1:0]       unit_sel;
  logic             mig_req;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  ret_unit_tuner #(.NUM_UNITS(4), .CNT_W(CNT_W)) u_ret_unit_tuner (
    .clk           (clk),
    .rst_n         (rst_n),
    .ivl_done      (ivl_done),
    .miss_cnt      (miss_cnt),
    .acc_cnt       (acc_cnt),
    .low_base_mode (low_base_mode),
    .mig_done      (mig_done),
    .unit_sel      (unit_sel),
    .mig_req       (mig_req)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic expect_out(input string tag, input int exp_sel, input bit exp_req);
    checks++;
    if (unit_sel !== exp_sel[1:0] || mig_req !== exp_req) begin
      errors++;
      $display("FAIL %s: unit_sel=%0d mig_req=%0b, expected unit_sel=%0d mig_req=%0b",
               tag, unit_sel, mig_req, exp_sel, exp_req);
    end
  endtask

  task automatic pulse_ivl(input int unsigned m, input int unsigned a);
    @(negedge clk);
    ivl_done = 1'b1;
    miss_cnt = m;
    acc_cnt  = a;
    @(negedge clk);
    ivl_done = 1'b0;
  endtask

  task automatic end_mig(input string tag, input int exp_sel);
    @(negedge clk);
    mig_done = 1'b1;
    @(negedge clk);
    mig_done = 1'b0;
    expect_out(tag, exp_sel, 1'b0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ivl_done = 1'b0; miss_cnt = '0; acc_cnt = '0;
    low_base_mode = 1'b0; mig_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1 reset state", 3, 1'b0);
  endtask

  // Reference 1000; 1040 passes (20800 < 21000); 1050 sits on the bound and fails.
  task automatic t_stop_on_reject();
    pulse_ivl(1000, 100000);
    expect_out("R2 baseline moves to unit 2", 2, 1'b1);
    repeat (3) @(negedge clk);
    expect_out("R8 request held without done", 2, 1'b1);
    pulse_ivl(99999, 100000);
    expect_out("R9 interval during migration ignored", 2, 1'b1);
    end_mig("R8 request drops after done", 2);
    pulse_ivl(1040, 100000);
    expect_out("R3 accept unit 2, try unit 1", 1, 1'b1);
    end_mig("R8 migration to unit 1 done", 1);
    pulse_ivl(1050, 100000);
    expect_out("R4 reject at bound, back to unit 2", 2, 1'b1);
    end_mig("R4 settled on unit 2", 2);
  endtask

  // Monitoring unit 2 with reference 1000: 1050 equal bound stays, 1051 drifts.
  task automatic t_monitor_drift();
    pulse_ivl(1050, 100000);
    expect_out("R6 equal bound no drift", 2, 1'b0);
    pulse_ivl(1051, 100000);
    expect_out("R6 drift to unit 3", 3, 1'b1);
    end_mig("R6 back on unit 3", 3);
  endtask

  // Reference 500; 500, 510, 520 all below 525 bound; end at unit 0.
  task automatic t_full_descent();
    pulse_ivl(500, 100000);
    expect_out("R2 new reference, unit 2", 2, 1'b1);
    end_mig("R8 at unit 2", 2);
    pulse_ivl(500, 100000);
    expect_out("R3 accept, unit 1", 1, 1'b1);
    end_mig("R8 at unit 1", 1);
    pulse_ivl(510, 100000);
    expect_out("R3 accept, unit 0", 0, 1'b1);
    end_mig("R8 at unit 0", 0);
    pulse_ivl(520, 100000);
    expect_out("R5 unit 0 accepted, no migration", 0, 1'b0);
    pulse_ivl(525, 100000);
    expect_out("R6 reference fixed, 525 no drift", 0, 1'b0);
    pulse_ivl(600, 100000);
    expect_out("R6 drift from unit 0", 3, 1'b1);
    end_mig("R6 returned to unit 3", 3);
  endtask

  // Low-rate mode: reference 100, accesses 1e6, limit miss < 500.
  task automatic t_low_rate();
    low_base_mode = 1'b1;
    pulse_ivl(100, 1000000);
    expect_out("R2 reference 100, unit 2", 2, 1'b1);
    end_mig("R8 at unit 2", 2);
    pulse_ivl(400, 1000000);
    expect_out("R7 low rate accepts unit 2", 1, 1'b1);
    end_mig("R8 at unit 1", 1);
    pulse_ivl(499, 1000000);
    expect_out("R7 low rate accepts unit 1", 0, 1'b1);
    end_mig("R8 at unit 0", 0);
    pulse_ivl(500, 1000000);
    expect_out("R7 rate at limit rejects, back to unit 1", 1, 1'b1);
    end_mig("R7 settled on unit 1", 1);
    pulse_ivl(499, 1000000);
    expect_out("R7 low rate suppresses drift", 1, 1'b0);
    pulse_ivl(600, 1000000);
    expect_out("R7 rate too high drifts", 3, 1'b1);
    end_mig("R7 back on unit 3", 3);
  endtask

  // Normal mode: same low-rate data is rejected; drift on unit 3 has no migration.
  task automatic t_retune_on_longest();
    low_base_mode = 1'b0;
    pulse_ivl(100, 1000000);
    expect_out("R2 reference 100", 2, 1'b1);
    end_mig("R8 at unit 2", 2);
    pulse_ivl(400, 1000000);
    expect_out("R7 rule off, reject to unit 3", 3, 1'b1);
    end_mig("R4 settled on unit 3", 3);
    pulse_ivl(106, 1000000);
    expect_out("R10 drift on unit 3, no migration", 3, 1'b0);
    pulse_ivl(200, 1000000);
    expect_out("R10 next interval is reference", 2, 1'b1);
    end_mig("R8 at unit 2", 2);
    pulse_ivl(210, 1000000);
    expect_out("R4 bound 210 vs reference 200 rejects", 3, 1'b1);
    end_mig("R4 settled on unit 3", 3);
  endtask

  initial begin
    t_reset();
    t_stop_on_reject();
    t_monitor_drift();
    t_full_descent();
    t_low_rate();
    t_retune_on_longest();
    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog: cycles=%0d expected below %0d", WATCHDOG, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule